// File: doc/BRIEF.md
# Conditional-Sum Prefix Adder Slice

This block adds two 8-bit operand slices and returns two sums at once: one formed as if the carry into the slice were 0, one as if it were 1. A wider carry-select stage above it picks between the two when the real carry into the slice is known. The slice also reports whether it generates a carry out by itself, and whether it passes an incoming carry straight through. The stage above uses these two signals to form its own carries.

Every bit position first forms a propagate term (XOR of the operand bits) and a generate term (AND of the operand bits). A parallel prefix network then builds, for each position i, the group generate and group propagate of bits i down to 0. Every node in the network computes both terms. The carry-in-1 sum and the slice-level propagate output need the prefix propagates, so no node may drop the propagate term, even where a plain carry-in-0 adder could. The network shape is chosen at elaboration time by a parameter. All shapes give the same result and differ only in depth, node count and fan-out. The block is purely combinational.

Top module: `cond_sum_prefix_slice`

## Requirements
- R1: `sum_c0_o` equals (`opa_i` + `opb_i`) mod 256.
- R2: `sum_c1_o` equals (`opa_i` + `opb_i` + 1) mod 256.
- R3: `grp_gen_o` is 1 exactly when `opa_i` + `opb_i` is 256 or more.
- R4: `grp_prop_o` is 1 exactly when `opa_i` XOR `opb_i` is all ones, that is, when the sum is exactly 255.
- R5: `grp_gen_o` and `grp_prop_o` are never both 1.
- R6: The results are the same for every value of the `TOPO` parameter. The encodings are 0 = one-level-per-distance full network, 1 = minimum-depth divide-and-conquer network, 2 = up-sweep/down-sweep network, 3 = odd-bit full network with a final even-bit fix-up level, 4 = hybrid with fan-outs 1,1,4 per level, 5 = hybrid with fan-outs 1,2,2, and 6 = hybrid with fan-outs 1,1,2.
- R7: Swapping `opa_i` and `opb_i` leaves all four outputs unchanged.
- R8: With both operands zero, the outputs are `sum_c0_o`=0x00, `sum_c1_o`=0x01, `grp_gen_o`=0 and `grp_prop_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH (8) | First operand slice |
| opb_i | input | WIDTH (8) | Second operand slice |
| sum_c0_o | output | WIDTH (8) | Sum assuming carry-in 0 |
| sum_c1_o | output | WIDTH (8) | Sum assuming carry-in 1 |
| grp_gen_o | output | 1 | Slice generates a carry out by itself |
| grp_prop_o | output | 1 | Slice passes an incoming carry through |

## Verification
The case that is hardest to reach is a carry-in-1 ripple through a long run of propagate positions. There the prefix propagate at the far end must be exact, and a network with a missing or misrouted propagate term still gives a correct carry-in-0 sum. The operands that cause this are those whose XOR is all ones or has a long run of ones. Such patterns are rare in random stimulus, so the bench applies all 65,536 operand pairs to one instance of every topology at once. It also walks a short table of hand-computed boundary vectors such as 0x55+0xAA, 0xFF+0x00 and 0xFF+0x01.

// File: rtl/cond_sum_prefix_pkg.sv
package cond_sum_prefix_pkg;

    localparam int SLICE_W = 8;

    typedef enum int {
        TOPO_KOGGE_STONE  = 0,
        TOPO_LADNER_FISCH = 1,
        TOPO_BRENT_KUNG   = 2,
        TOPO_HAN_CARLSON  = 3,
        TOPO_HYB_114      = 4,
        TOPO_HYB_122      = 5,
        TOPO_HYB_112      = 6
    } pfx_topo_e;

    localparam int TOPO_COUNT = 7;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Fan-out per level for the regular-fan-out family.
    function automatic int pfx_fanout(pfx_topo_e topo, int lvl);
        int f;
        case (topo)
            TOPO_LADNER_FISCH: f = 1 << lvl;
            TOPO_HYB_114:      f = (lvl == 2) ? 4 : 1;
            TOPO_HYB_122:      f = (lvl == 0) ? 1 : 2;
            TOPO_HYB_112:      f = (lvl == 2) ? 2 : 1;
            default:           f = 1;
        endcase
        if (f > (1 << lvl)) f = 1 << lvl;
        return f;
    endfunction

    // Index of the lower-significance partner of node i at level lvl,
    // or -1 when the node just passes its value on.
    function automatic int pfx_link(pfx_topo_e topo, int lvl, int i, int lg);
        int d;
        int k;
        int f;
        case (topo)
            TOPO_BRENT_KUNG: begin
                if (lvl < lg) begin
                    d = 1 << lvl;
                    if (((i + 1) % (2 * d)) == 0) return i - d;
                end else begin
                    k = lg - 2 - (lvl - lg);
                    if (k >= 0) begin
                        d = 1 << k;
                        if ((((i + 1) % (2 * d)) == d) && (i >= 2 * d)) return i - d;
                    end
                end
            end
            TOPO_HAN_CARLSON: begin
                if (lvl == 0) begin
                    if ((i % 2) == 1) return i - 1;
                end else if (lvl < lg) begin
                    d = 1 << lvl;
                    if (((i % 2) == 1) && (i >= d + 1)) return i - d;
                end else if (lvl == lg) begin
                    if (((i % 2) == 0) && (i >= 2)) return i - 1;
                end
            end
            default: begin
                if (lvl < lg) begin
                    d = 1 << lvl;
                    f = pfx_fanout(topo, lvl);
                    if (i >= d) return ((i - d) / f) * f + f - 1;
                end
            end
        endcase
        return -1;
    endfunction

endpackage

// File: rtl/pfx_bit_cell.sv
module pfx_bit_cell
    import cond_sum_prefix_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    output gp_t  gp_o
);
    assign gp_o.g = a_i & b_i;
    assign gp_o.p = a_i ^ b_i;

    // R5
    always_comb begin
        bit_excl_chk: assert (!(gp_o.g && gp_o.p))
            else $error("bit cell drives generate and propagate together");
    end
endmodule

// File: rtl/pfx_node.sv
module pfx_node
    import cond_sum_prefix_pkg::*;
(
    input  gp_t hi_i,
    input  gp_t lo_i,
    output gp_t gp_o
);
    assign gp_o.g = hi_i.g | (hi_i.p & lo_i.g);
    assign gp_o.p = hi_i.p & lo_i.p;

    // R5
    always_comb begin
        if (!(hi_i.g && hi_i.p) && !(lo_i.g && lo_i.p)) begin
            node_excl_chk: assert (!(gp_o.g && gp_o.p))
                else $error("prefix node merged into generate and propagate both set");
        end
    end
endmodule

// File: rtl/pfx_network.sv
module pfx_network
    import cond_sum_prefix_pkg::*;
#(
    parameter int        WIDTH = SLICE_W,
    parameter pfx_topo_e TOPO  = TOPO_KOGGE_STONE
) (
    input  gp_t [WIDTH-1:0] bit_i,
    output gp_t [WIDTH-1:0] pre_o
);
    localparam int LG     = $clog2(WIDTH);
    localparam int LEVELS = (2 * LG) - 1;

    gp_t [WIDTH-1:0] stage [LEVELS+1];

    assign stage[0] = bit_i;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            localparam int SRC = pfx_link(TOPO, lv, i, LG);
            if (SRC >= 0) begin : g_node
                pfx_node u_node (
                    .hi_i (stage[lv][i]),
                    .lo_i (stage[lv][SRC]),
                    .gp_o (stage[lv+1][i])
                );
            end else begin : g_pass
                assign stage[lv+1][i] = stage[lv][i];
            end
        end
    end

    assign pre_o = stage[LEVELS];

    // R3 R4: top position must agree with a direct fold of the bit terms
    logic fold_g;
    logic fold_p;
    always_comb begin
        fold_g = 1'b0;
        fold_p = 1'b1;
        for (int j = 0; j < WIDTH; j++) begin
            fold_g = bit_i[j].g | (bit_i[j].p & fold_g);
            fold_p = fold_p & bit_i[j].p;
        end
    end

    // R3
    always_comb begin
        top_gen_chk: assert (pre_o[WIDTH-1].g == fold_g)
            else $error("prefix network top generate mismatch");
    end
    // R4
    always_comb begin
        top_prop_chk: assert (pre_o[WIDTH-1].p == fold_p)
            else $error("prefix network top propagate mismatch");
    end
endmodule

// File: rtl/pfx_sum_select.sv
module pfx_sum_select
    import cond_sum_prefix_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  gp_t [WIDTH-1:0]  bit_i,
    input  gp_t [WIDTH-1:0]  pre_i,
    output logic [WIDTH-1:0] sum0_o,
    output logic [WIDTH-1:0] sum1_o
);
    assign sum0_o[0] = bit_i[0].p;
    assign sum1_o[0] = ~bit_i[0].p;

    for (genvar i = 1; i < WIDTH; i++) begin : g_sum
        assign sum0_o[i] = bit_i[i].p ^ pre_i[i-1].g;
        assign sum1_o[i] = bit_i[i].p ^ (pre_i[i-1].g | pre_i[i-1].p);
    end
endmodule

// File: rtl/cond_sum_prefix_slice.sv
module cond_sum_prefix_slice
    import cond_sum_prefix_pkg::*;
#(
    parameter int        WIDTH = SLICE_W,
    parameter pfx_topo_e TOPO  = TOPO_KOGGE_STONE
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] sum_c0_o,
    output logic [WIDTH-1:0] sum_c1_o,
    output logic             grp_gen_o,
    output logic             grp_prop_o
);
    gp_t [WIDTH-1:0] bit_gp;
    gp_t [WIDTH-1:0] pre_gp;

    for (genvar i = 0; i < WIDTH; i++) begin : g_ha
        pfx_bit_cell u_ha (
            .a_i  (opa_i[i]),
            .b_i  (opb_i[i]),
            .gp_o (bit_gp[i])
        );
    end

    pfx_network #(
        .WIDTH (WIDTH),
        .TOPO  (TOPO)
    ) u_net (
        .bit_i (bit_gp),
        .pre_o (pre_gp)
    );

    pfx_sum_select #(
        .WIDTH (WIDTH)
    ) u_sel (
        .bit_i  (bit_gp),
        .pre_i  (pre_gp),
        .sum0_o (sum_c0_o),
        .sum1_o (sum_c1_o)
    );

    assign grp_gen_o  = pre_gp[WIDTH-1].g;
    assign grp_prop_o = pre_gp[WIDTH-1].p;

    // R1 R3
    always_comb begin
        carry_sum_chk: assert ({grp_gen_o, sum_c0_o} == ({1'b0, opa_i} + {1'b0, opb_i}))
            else $error("carry-in-0 sum or carry out wrong");
    end
    // R2
    always_comb begin
        sum_pair_chk: assert (sum_c1_o == WIDTH'(sum_c0_o + 1'b1))
            else $error("carry-in-1 sum is not one above carry-in-0 sum");
    end
    // R5
    always_comb begin
        grp_excl_chk: assert (!(grp_gen_o && grp_prop_o))
            else $error("group generate and propagate both set");
    end
endmodule

// File: tb/cond_sum_prefix_slice_tb.sv
`timescale 1ns/100ps
module cond_sum_prefix_slice_tb;
    import cond_sum_prefix_pkg::*;

    localparam int W  = SLICE_W;
    localparam int NT = TOPO_COUNT;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic [W-1:0] s0_w [NT];
    logic [W-1:0] s1_w [NT];
    logic         g_w  [NT];
    logic         p_w  [NT];

    for (genvar k = 0; k < NT; k++) begin : g_topo
        logic [W-1:0] s0, s1;
        logic         gg, pp;
        cond_sum_prefix_slice #(
            .WIDTH (W),
            .TOPO  (pfx_topo_e'(k))
        ) u_dut (
            .opa_i      (opa),
            .opb_i      (opb),
            .sum_c0_o   (s0),
            .sum_c1_o   (s1),
            .grp_gen_o  (gg),
            .grp_prop_o (pp)
        );
        assign s0_w[k] = s0;
        assign s1_w[k] = s1;
        assign g_w[k]  = gg;
        assign p_w[k]  = pp;
    end

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s a=%02h b=%02h actual=%0h expected=%0h", req, opa, opb, act, exp);
        end
    endtask

    // {a, b, sum_c0, sum_c1, gen, prop}
    localparam int NV = 9;
    localparam logic [33:0] VEC [NV] = '{
        {8'h00, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0},
        {8'hFF, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1},
        {8'hFF, 8'h01, 8'h00, 8'h01, 1'b1, 1'b0},
        {8'h80, 8'h80, 8'h00, 8'h01, 1'b1, 1'b0},
        {8'h55, 8'hAA, 8'hFF, 8'h00, 1'b0, 1'b1},
        {8'h0F, 8'h01, 8'h10, 8'h11, 1'b0, 1'b0},
        {8'h7F, 8'h7F, 8'hFE, 8'hFF, 1'b0, 1'b0},
        {8'hFF, 8'hFF, 8'hFE, 8'hFF, 1'b1, 1'b0},
        {8'h3C, 8'hC3, 8'hFF, 8'h00, 1'b0, 1'b1}
    };

    initial begin
        int tot;
        int e0, e1;
        bit eg, ep;
        opa = '0;
        opb = '0;
        #2.5;
        // R8: idle outputs with zero operands
        for (int k = 0; k < NT; k++) begin
            chk(s0_w[k] == 8'h00, "R8", s0_w[k], 0);
            chk(s1_w[k] == 8'h01, "R8", s1_w[k], 1);
            chk(g_w[k] == 1'b0 && p_w[k] == 1'b0, "R8", {g_w[k], p_w[k]}, 0);
        end

        // Table of hand-computed boundary vectors (R1 R2 R3 R4)
        for (int v = 0; v < NV; v++) begin
            opa = VEC[v][33:26];
            opb = VEC[v][25:18];
            #1;
            for (int k = 0; k < NT; k++) begin
                chk(s0_w[k] == VEC[v][17:10], "R1", s0_w[k], VEC[v][17:10]);
                chk(s1_w[k] == VEC[v][9:2],   "R2", s1_w[k], VEC[v][9:2]);
                chk(g_w[k]  == VEC[v][1],     "R3", g_w[k], VEC[v][1]);
                chk(p_w[k]  == VEC[v][0],     "R4", p_w[k], VEC[v][0]);
            end
            #1;
        end

        // Exhaustive sweep across every topology (R1 R2 R3 R4 R5 R6)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                opa = W'(a);
                opb = W'(b);
                #1;
                tot = a + b;
                e0  = tot % 256;
                e1  = (tot + 1) % 256;
                eg  = (tot >= 256);
                ep  = ((a ^ b) == 255);
                for (int k = 0; k < NT; k++) begin
                    chk(s0_w[k] == W'(e0), "R1", s0_w[k], e0);
                    chk(s1_w[k] == W'(e1), "R2", s1_w[k], e1);
                    chk(g_w[k] == eg, "R3", g_w[k], eg);
                    chk(p_w[k] == ep, "R4", p_w[k], ep);
                    chk(!(g_w[k] && p_w[k]), "R5", {g_w[k], p_w[k]}, 0);
                    chk(s0_w[k] == s0_w[0] && s1_w[k] == s1_w[0], "R6", k, 0);
                end
                #1;
            end
        end

        // R7: operand swap on asymmetric pairs
        for (int v = 0; v < 4; v++) begin
            logic [W-1:0] ra, rb, r0, r1;
            logic rg, rp;
            ra = W'(8'h13 + v * 8'h47);
            rb = W'(8'hE9 - v * 8'h21);
            opa = ra; opb = rb;
            #1;
            r0 = s0_w[2]; r1 = s1_w[2]; rg = g_w[2]; rp = p_w[2];
            #1;
            opa = rb; opb = ra;
            #1;
            chk(s0_w[2] == r0 && s1_w[2] == r1 && g_w[2] == rg && p_w[2] == rp,
                "R7", {s0_w[2], s1_w[2]}, {r0, r1});
            #1;
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule